// File: doc/BRIEF.md
# Bidirectional latched byte transceiver

This block moves a byte between two ports, A and B, in either direction. Each direction owns a bank of storage that can either pass the source data straight through or hold a captured copy. Three active-low controls govern each direction. A direction enable gates both loading and driving. A load control makes the bank transparent. An output control lets the bank drive the far port. The path never inverts data.

Each bidirectional pin group is split into an input vector, an output vector and one drive flag, so no tristate buffer is needed. Storage is a clocked emulation of a latch. While the bank is transparent, the far port follows the source input in the same cycle. The bank also records the source on every rising clock edge. When the load control is released, the bank keeps the value recorded at the last edge at which it was still transparent. Reset clears both banks to zero. The block does not arbitrate: if both directions are set to drive at once, both drive, and avoiding that conflict is left to the surrounding logic.

Top module: `latched_xcvr`

## Requirements
- R1: With the A-to-B enable, load and output controls all low, `b_oe` is 1 and `b_out` equals `a_in` bit for bit, with no inversion, in the same cycle.
- R2: With the B-to-A enable, load and output controls all low, `a_oe` is 1 and `a_out` equals `b_in` bit for bit, with no inversion, in the same cycle.
- R3: While a direction's enable is high, its bank keeps its contents whatever its load control and source input do, and its drive flag is 0.
- R4: While a direction's enable and load control are both low, the bank is transparent. It records its source input at every rising clock edge, and its output follows the source combinationally.
- R5: After the load control goes high with the enable low, the bank keeps the value recorded at the last rising edge at which it was transparent. Later changes of the source input do not reach the output.
- R6: A direction drives its destination port only when its enable and output control are both low. It then presents the bank output, whether that is transparent or held.
- R7: While a direction's output control is high, its drive flag is 0, whatever its enable is.
- R8: The two directions are independent. Each holds its own data, and both may drive at the same time without arbitration.
- R9: During and right after reset, both banks hold 0x00. Their first driven value without a transparent phase is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank storage |
| rst_n | input | 1 | Active-low reset; clears both banks |
| a_in | input | 8 | Data arriving on the A side |
| a_out | output | 8 | Data presented on the A side (B-to-A bank output) |
| a_oe | output | 1 | A side is driven when 1 |
| b_in | input | 8 | Data arriving on the B side |
| b_out | output | 8 | Data presented on the B side (A-to-B bank output) |
| b_oe | output | 1 | B side is driven when 1 |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B load control, active low (transparent) |
| ab_oe_n | input | 1 | A-to-B output control, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A load control, active low (transparent) |
| ba_oe_n | input | 1 | B-to-A output control, active low |

## Verification
The bench closes a bank and then changes the source. A design that captured on the wrong edge, or kept following the input, would show the new byte instead of the held one. It raises the enable while the load control stays low. A bank that ignored the enable would overwrite its data, and a bad output decode would keep driving. It also runs both directions at once with different bytes. Shared or crossed storage would show up as the wrong byte on one side.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int unsigned XCVR_W = 8;

  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctl_t;

  function automatic logic is_open(input dir_ctl_t c);
    return (c.en_n == 1'b0) && (c.le_n == 1'b0);
  endfunction

  function automatic logic is_driving(input dir_ctl_t c);
    return (c.en_n == 1'b0) && (c.oe_n == 1'b0);
  endfunction
endpackage

// File: rtl/xcvr_ctl.sv
module xcvr_ctl
  import xcvr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dir_ctl_t ctl,
  output logic     open,
  output logic     drive
);
  assign open  = is_open(ctl);
  assign drive = is_driving(ctl);

  a_r7_no_drive_when_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.oe_n |-> !drive);
  a_r3_no_drive_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.en_n |-> (!drive && !open));
endmodule

// File: rtl/xcvr_bank.sv
module xcvr_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (open) held <= src;
  end

  assign q = open ? src : held;

  a_r4_capture_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    open |=> (held == $past(src)));
  a_r5_hold_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(held));
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] src,
  output logic [W-1:0] dst,
  output logic         dst_oe
);
  logic open_w;
  logic drive_w;

  xcvr_ctl u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .open  (open_w),
    .drive (drive_w)
  );

  xcvr_bank #(.W(W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .open  (open_w),
    .src   (src),
    .q     (dst)
  );

  assign dst_oe = drive_w;

  a_r6_transparent_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_oe && open_w) |-> (dst == src));
endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_en_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_en_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n
);
  localparam int unsigned NDIR = 2;

  dir_ctl_t       ctl_v [NDIR];
  logic [W-1:0]   src_v [NDIR];
  logic [W-1:0]   dst_v [NDIR];
  logic [NDIR-1:0] oe_v;

  assign ctl_v[0] = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
  assign ctl_v[1] = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
  assign src_v[0] = a_in;
  assign src_v[1] = b_in;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_path #(.W(W)) u_path (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctl    (ctl_v[d]),
      .src    (src_v[d]),
      .dst    (dst_v[d]),
      .dst_oe (oe_v[d])
    );
  end

  assign b_out = dst_v[0];
  assign b_oe  = oe_v[0];
  assign a_out = dst_v[1];
  assign a_oe  = oe_v[1];

  a_r1_ab_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && !ab_le_n && !ab_oe_n) |-> (b_oe && b_out == a_in));
  a_r2_ba_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_en_n && !ba_le_n && !ba_oe_n) |-> (a_oe && a_out == b_in));
  a_r8_independent_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_en_n && !ab_oe_n && !ba_en_n && !ba_oe_n) |-> (a_oe && b_oe));
endmodule

// File: tb/latched_xcvr_test.sv
`timescale 1ns/1ps
module latched_xcvr_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] a_in = 8'h00, b_in = 8'h00;
  logic [7:0] a_out, b_out;
  logic a_oe, b_oe;
  logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;

  int checks = 0;
  int failures = 0;
  int held_ab = 0;
  int held_ba = 0;

  always #10 clk = ~clk;

  latched_xcvr uut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference: compare all visible outputs against the behavioural model.
  task automatic compare(input string tag);
    int exp_b, exp_a;
    bit drv_b, drv_a;
    drv_b = (ab_en_n == 0) && (ab_oe_n == 0);
    drv_a = (ba_en_n == 0) && (ba_oe_n == 0);
    exp_b = (ab_en_n == 0 && ab_le_n == 0) ? int'(a_in) : held_ab;
    exp_a = (ba_en_n == 0 && ba_le_n == 0) ? int'(b_in) : held_ba;
    chk({tag, " b_oe"}, int'(b_oe), int'(drv_b));
    chk({tag, " a_oe"}, int'(a_oe), int'(drv_a));
    if (drv_b) chk({tag, " b_out"}, int'(b_out), exp_b);
    if (drv_a) chk({tag, " a_out"}, int'(a_out), exp_a);
  endtask

  // Apply settings at the falling edge, compare mid-low phase, then
  // advance the model over the next rising edge.
  task automatic step(input string tag,
                      input logic [7:0] av, input logic [7:0] bv,
                      input logic [2:0] ab, input logic [2:0] ba);
    @(negedge clk);
    a_in = av; b_in = bv;
    {ab_en_n, ab_le_n, ab_oe_n} = ab;
    {ba_en_n, ba_le_n, ba_oe_n} = ba;
    #5;
    compare(tag);
    @(posedge clk);
    #1;
    if (ab_en_n == 0 && ab_le_n == 0) held_ab = int'(a_in);
    if (ba_en_n == 0 && ba_le_n == 0) held_ba = int'(b_in);
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R9 reset a_oe", int'(a_oe), 0);
    chk("R9 reset b_oe", int'(b_oe), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // {en_n, le_n, oe_n}
    step("R9 ab drive after reset",    8'h11, 8'h22, 3'b010, 3'b010);
    step("R1 R4 ab transparent A5",    8'hA5, 8'h00, 3'b000, 3'b111);
    step("R1 R4 ab transparent 3C",    8'h3C, 8'h00, 3'b000, 3'b111);
    step("R5 ab close load",           8'h3C, 8'h00, 3'b010, 3'b111);
    step("R5 R6 ab held after change", 8'hFF, 8'h00, 3'b010, 3'b111);
    step("R7 ab oe high",              8'h0F, 8'h00, 3'b011, 3'b111);
    step("R3 ab disabled load low",    8'h81, 8'h00, 3'b100, 3'b111);
    step("R3 ab disabled again",       8'h7E, 8'h00, 3'b100, 3'b111);
    step("R3 R6 ab hold kept",         8'h55, 8'h00, 3'b010, 3'b111);
    step("R2 R4 ba transparent C3",    8'h55, 8'hC3, 3'b111, 3'b000);
    step("R2 R4 ba transparent 01",    8'h55, 8'h01, 3'b111, 3'b000);
    step("R5 ba close",                8'h55, 8'h01, 3'b111, 3'b010);
    step("R5 R6 ba held after change", 8'h55, 8'hEE, 3'b111, 3'b010);
    step("R7 ba oe high enabled",      8'h55, 8'hEE, 3'b111, 3'b011);
    step("R7 ba oe high disabled",     8'h55, 8'hEE, 3'b111, 3'b101);
    step("R8 both transparent",        8'h96, 8'h69, 3'b000, 3'b000);
    step("R8 both held",               8'h00, 8'hFF, 3'b010, 3'b010);
    step("R8 ab only loads",           8'h5A, 8'h00, 3'b000, 3'b010);
    step("R8 ba kept",                 8'h00, 8'h00, 3'b010, 3'b010);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule